// File: doc/BRIEF.md
# Bus Handoff Controller

This block lets an external master take over the processor's external address bus, data bus and memory strobes. The external master raises a request. The controller passes that request through a synchronizer. It then waits until the processor has no external memory access in flight. At that point it grants the bus. In the same cycle it turns off the output drivers of both buses and of every strobe line, and it halts the core.

When the request is withdrawn, the controller hands the bus back in a fixed order. Grant drops first, while the drivers are still off. In the next cycle the drivers are re-enabled, but the strobes are held at their inactive level. One cycle later the strobe hold is released and the core resumes.

The controller is a four-state Moore machine:

- **ST_OWNED**: the processor owns the bus.
- **ST_GRANTED**: the external master owns the bus.
- **ST_RETURN**: grant has been withdrawn and the drivers are still off.
- **ST_SETTLE**: the drivers are back on and the strobes are held inactive.

Its transitions are:

- **T_TAKE**: ST_OWNED to ST_GRANTED, taken when the synchronized request is high and the core is not busy.
- **T_DROP**: ST_GRANTED to ST_RETURN, taken when the synchronized request is low.
- **T_REDRIVE**: ST_RETURN to ST_SETTLE, taken unconditionally.
- **T_RESUME**: ST_SETTLE to ST_OWNED, taken unconditionally.

Each state holds by self-loop while its exit condition is false.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: During and right after reset, the block is in ST_OWNED. Grant is 0, every output enable is 1, the strobe hold is 0 and halt is 0.
- R2: The request passes through SYNC_STAGES flip-flops (default 2). With the core idle, grant is still 0 after the second rising edge following a request rise. Grant is 1 after the third edge.
- R3: Grant never rises while the core's external-access-busy input is high. If the synchronized request is already high, grant rises at the first rising edge at which busy is low.
- R4: While grant is 1, the address and data enables and every strobe enable are 0, and halt is 1.
- R5: Grant falls at the first rising edge at which the synchronized request is low. For the cycle that follows, all enables stay 0 and halt stays 1.
- R6: One cycle after grant falls, all enables return to 1. The strobe hold is 1 and halt is still 1.
- R7: Two cycles after grant falls, the strobe hold returns to 0 and halt returns to 0.
- R8: A request that reappears during ST_RETURN or ST_SETTLE does not shorten the return sequence. Grant rises again one cycle after ST_OWNED is reached, so grant is low for exactly three cycles.
- R9: While grant is 1, the busy input has no effect. Grant stays high until the request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Asynchronous bus request from the external master, active high |
| core_xfer_busy_i | input | 1 | High while the core has an external memory access in flight |
| bus_grant_o | output | 1 | Bus grant to the external master, active high |
| addr_oe_o | output | 1 | Address bus driver enable, 1 = driven |
| data_oe_o | output | 1 | Data bus driver enable, 1 = driven |
| strobe_oe_o | output | NUM_STROBES | Per-strobe driver enable (select, read, write lines), 1 = driven |
| strobe_hold_idle_o | output | 1 | Forces all strobes to their inactive level |
| core_halt_o | output | 1 | Halts program execution, active high |

## Verification
Every state decodes to a distinct output pattern. A wrong state or a wrong transition therefore shows at the ports in the very cycle it is entered:

- a grant together with driven buses;
- a halt without a grant or a return sequence in progress;
- a return sequence longer or shorter than two cycles.

The bench steps the request, the busy input and early re-requests cycle by cycle, and compares the whole output pattern at each step. A synchronizer that is too short or too long shows as a grant one edge early or late.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [1:0] {
        ST_OWNED   = 2'd0,
        ST_GRANTED = 2'd1,
        ST_RETURN  = 2'd2,
        ST_SETTLE  = 2'd3
    } bhc_state_e;

    typedef struct packed {
        logic grant;
        logic addr_oe;
        logic data_oe;
        logic strobe_en;
        logic strobe_idle;
        logic halt;
    } bhc_outs_t;

endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
    import bhc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_sync,
    input  logic       core_busy,
    output bhc_state_e state
);

    bhc_state_e state_q;
    bhc_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OWNED;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWNED: begin
                // T_TAKE: only between processor external accesses
                if (req_sync && !core_busy) state_d = ST_GRANTED;
            end
            ST_GRANTED: begin
                // T_DROP: request withdrawn, busy is not looked at here
                if (!req_sync) state_d = ST_RETURN;
            end
            ST_RETURN: begin
                // T_REDRIVE
                state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                // T_RESUME
                state_d = ST_OWNED;
            end
            default: state_d = ST_OWNED;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bhc_outdec.sv
module bhc_outdec
    import bhc_pkg::*;
#(
    parameter int NUM_STROBES = 5
) (
    input  bhc_state_e             state,
    output logic                   grant,
    output logic                   addr_oe,
    output logic                   data_oe,
    output logic [NUM_STROBES-1:0] strobe_oe,
    output logic                   strobe_idle,
    output logic                   halt
);

    bhc_outs_t outs;

    // Output decode
    always_comb begin
        outs = '{grant: 1'b0, addr_oe: 1'b1, data_oe: 1'b1,
                 strobe_en: 1'b1, strobe_idle: 1'b0, halt: 1'b0};
        unique case (state)
            ST_OWNED: ;
            ST_GRANTED: begin
                outs.grant     = 1'b1;
                outs.addr_oe   = 1'b0;
                outs.data_oe   = 1'b0;
                outs.strobe_en = 1'b0;
                outs.halt      = 1'b1;
            end
            ST_RETURN: begin
                outs.addr_oe   = 1'b0;
                outs.data_oe   = 1'b0;
                outs.strobe_en = 1'b0;
                outs.halt      = 1'b1;
            end
            ST_SETTLE: begin
                outs.strobe_idle = 1'b1;
                outs.halt        = 1'b1;
            end
            default: ;
        endcase
    end

    assign grant       = outs.grant;
    assign addr_oe     = outs.addr_oe;
    assign data_oe     = outs.data_oe;
    assign strobe_idle = outs.strobe_idle;
    assign halt        = outs.halt;

    generate
        for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strobe
            assign strobe_oe[i] = outs.strobe_en;
        end
    endgenerate

endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
    import bhc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_STROBES = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req_i,
    input  logic                   core_xfer_busy_i,
    output logic                   bus_grant_o,
    output logic                   addr_oe_o,
    output logic                   data_oe_o,
    output logic [NUM_STROBES-1:0] strobe_oe_o,
    output logic                   strobe_hold_idle_o,
    output logic                   core_halt_o
);

    logic       req_sync;
    bhc_state_e state;

    bhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bus_req_i),
        .q_sync  (req_sync)
    );

    bhc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_sync  (req_sync),
        .core_busy (core_xfer_busy_i),
        .state     (state)
    );

    bhc_outdec #(.NUM_STROBES(NUM_STROBES)) u_outdec (
        .state       (state),
        .grant       (bus_grant_o),
        .addr_oe     (addr_oe_o),
        .data_oe     (data_oe_o),
        .strobe_oe   (strobe_oe_o),
        .strobe_idle (strobe_hold_idle_o),
        .halt        (core_halt_o)
    );

endmodule

// File: rtl/bus_handoff_ctrl_chk.sv
module bus_handoff_ctrl_chk #(
    parameter int NUM_STROBES = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   grant,
    input logic                   addr_oe,
    input logic                   data_oe,
    input logic [NUM_STROBES-1:0] strobe_oe,
    input logic                   strobe_idle,
    input logic                   halt
);

    AST_GRANT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (!addr_oe && !data_oe && strobe_oe == '0)); // R4

    AST_GRANT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> halt); // R4

    AST_NO_GRANT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> !$past(busy)); // R3

    AST_DROP_KEEPS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant) |-> (!addr_oe && !data_oe && strobe_oe == '0 && halt)); // R5

    AST_REDRIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant) |=> (addr_oe && data_oe && (&strobe_oe) && strobe_idle && halt)); // R6

    AST_QUIET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_idle |=> (!strobe_idle && !halt && !grant)); // R7

    AST_QUIET_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_idle |-> (&strobe_oe)); // R6

endmodule

bind bus_handoff_ctrl bus_handoff_ctrl_chk #(.NUM_STROBES(NUM_STROBES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (core_xfer_busy_i),
    .grant       (bus_grant_o),
    .addr_oe     (addr_oe_o),
    .data_oe     (data_oe_o),
    .strobe_oe   (strobe_oe_o),
    .strobe_idle (strobe_hold_idle_o),
    .halt        (core_halt_o)
);

// File: tb/bus_handoff_ctrl_test.sv
`timescale 1ns/1ps
module bus_handoff_ctrl_test;

    localparam int NS = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          busy = 1'b0;
    logic          grant, aoe, doe, idle, halt;
    logic [NS-1:0] soe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    bus_handoff_ctrl #(.SYNC_STAGES(2), .NUM_STROBES(NS)) uut (
        .clk                (clk),
        .rst_n              (rst_n),
        .bus_req_i          (req),
        .core_xfer_busy_i   (busy),
        .bus_grant_o        (grant),
        .addr_oe_o          (aoe),
        .data_oe_o          (doe),
        .strobe_oe_o        (soe),
        .strobe_hold_idle_o (idle),
        .core_halt_o        (halt)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compares the full output pattern {grant, aoe, doe, soe-all, idle, halt}
    task automatic expect_outs(input string tag, input logic g, input logic a,
                               input logic d, input logic s, input logic i,
                               input logic h);
        logic [5:0] act, exp;
        logic       s_ok;
        s_ok = s ? (soe == {NS{1'b1}}) : (soe == '0);
        act  = {grant, aoe, doe, s_ok ? s : ~s, idle, halt};
        exp  = {g, a, d, s, i, h};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got g/a/d/s/i/h=%b expected %b (soe=%b)",
                     tag, act, exp, soe);
        end
    endtask

    task automatic t_reset();
        step(1);
        expect_outs("R1 in reset", 0, 1, 1, 1, 0, 0);
        rst_n = 1'b1;
        step(2);
        expect_outs("R1 after reset", 0, 1, 1, 1, 0, 0);
    endtask

    // Starts from ST_OWNED, leaves the block granted
    task automatic t_grant_latency();
        req = 1'b1;
        step(2);
        expect_outs("R2 no grant after two edges", 0, 1, 1, 1, 0, 0);
        step(1);
        expect_outs("R2 R4 grant on third edge", 1, 0, 0, 0, 0, 1);
    endtask

    // Starts granted, ends in ST_OWNED
    task automatic t_release();
        req = 1'b0;
        step(2);
        expect_outs("R5 grant held while sync drains", 1, 0, 0, 0, 0, 1);
        step(1);
        expect_outs("R5 grant drops, drivers off", 0, 0, 0, 0, 0, 1);
        step(1);
        expect_outs("R6 drivers on, strobes quiet", 0, 1, 1, 1, 1, 1);
        step(1);
        expect_outs("R7 resumed", 0, 1, 1, 1, 0, 0);
    endtask

    task automatic t_busy_defer();
        busy = 1'b1;
        req  = 1'b1;
        step(6);
        expect_outs("R3 deferred while busy", 0, 1, 1, 1, 0, 0);
        busy = 1'b0;
        step(1);
        expect_outs("R3 grant right after busy clears", 1, 0, 0, 0, 0, 1);
    endtask

    task automatic t_busy_ignored();
        busy = 1'b1;
        step(4);
        expect_outs("R9 busy ignored while granted", 1, 0, 0, 0, 0, 1);
        busy = 1'b0;
    endtask

    task automatic t_rerequest();
        req = 1'b0;
        step(3);
        expect_outs("R8 return entered", 0, 0, 0, 0, 0, 1);
        req = 1'b1;
        step(1);
        expect_outs("R8 settle not skipped", 0, 1, 1, 1, 1, 1);
        step(1);
        expect_outs("R8 owned for one cycle", 0, 1, 1, 1, 0, 0);
        step(1);
        expect_outs("R8 regrant", 1, 0, 0, 0, 0, 1);
    endtask

    initial begin
        t_reset();
        t_grant_latency();
        t_release();
        t_busy_defer();
        t_busy_ignored();
        t_release();
        t_grant_latency();
        t_rerequest();
        t_release();
        step(2);
        expect_outs("R1 idle at end", 0, 1, 1, 1, 0, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule